// File: doc/BRIEF.md
# I/O Translation Unit Control and Fault Register File

This block is the software-visible register file of an I/O address translation unit. A host reaches it through a simple word-wide register bus: one request per cycle, with a write strobe and a word index. Each register applies its own write mask and hardwired bits. The control word's 3-bit range code sets the lowest address of the translated window, which always ends at the top of the 32-bit space. The control word's enable bit and the page-table base are also driven out to the companion translator.

When the translator finds a missing or write-protected mapping, it pulses a fault report together with the page address and a read/write flag. The block then loads the fault status and fault address registers and raises a registered, level-sensitive interrupt. Software clears the interrupt by reading either fault register or by writing either fault register. The flush, slot configuration and arbitration values are only stored and read back.

Word map (index on `bus_addr`): 0 control, 1 page-table base, 2 flush-all, 3 flush-page, 4 fault status, 5 fault address, 6 arbiter enable, 7 arbitration enable, 8 to 8+NUM_SLOTS-1 slot configuration, 8+NUM_SLOTS mask ID. All other indexes are unmapped.

Top module: `iommu_regs`

## Requirements
- R1: After reset, the registers read as follows: control = {VERSION, 24'h0}, arbitration enable = 0x00000008, fault status = 0x00800000, arbiter enable = 0x00000003 and mask ID = MASK_ID_RST. Every other register reads 0, and `win_start`, `xlate_en` and `irq` are 0.
- R2: A control write stores the data ANDed with 0x0000001D, and bits [31:24] always read as VERSION. `xlate_en` follows stored bit 0 from the cycle after the write.
- R3: From the cycle after a control write, `win_start` equals 0xFFFFFFFF shifted left by (24 + code), where code is data bits [4:2]. Code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: The page-table base keeps only the data bits in 0x07FFFC00. The two flush registers keep all 32 bits.
- R5: The arbiter enable register keeps the data bits in 0x801F000F and always reads bit 0 as 1. The arbitration enable register keeps the data bits in 0x001F0000 and always reads bit 3 as 1.
- R6: Each slot configuration register keeps the data bits in 0x00010003. A write to one slot leaves the other slots unchanged.
- R7: A mask ID write ORs the data's low 24 bits into the current contents and never clears a bit.
- R8: A fault status write stores the data ANDed with 0xFF0FFFFF, forces bit 23 to 1, and drops `irq` in the next cycle.
- R9: A fault report loads fault status with bits 31, 30, 23 and 17 set, plus bit 18 if the faulting access was a read. It loads fault address with `flt_page`, and `irq` reads 1 from the next cycle.
- R10: A read of fault status, or a read or write of fault address, drops `irq` in the next cycle. A fault address write stores all 32 bits. Accesses to other registers leave `irq` unchanged.
- R11: When a fault report arrives in the same cycle as a bus access to a fault register, the fault wins. The captured status and address are kept, the bus write to that register is discarded, and `irq` reads 1.
- R12: Unmapped word indexes read as 0, and writes to them change no register.
- R13: A read request returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle later. A cycle with no read request gives `bus_rvalid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| flt_report | input | 1 | Translation fault pulse |
| flt_is_read | input | 1 | Faulting access was a read |
| flt_page | input | 32 | Page address of the fault |
| xlate_en | output | 1 | Translation enable (control bit 0) |
| win_start | output | 32 | Lowest address of the translated window |
| pt_base | output | 32 | Page-table base register |
| irq | output | 1 | Fault interrupt, level |

## Verification
Fault capture and a software access to the fault registers can fall in the same cycle. Here the interrupt set and clear, and the bus write and capture load, compete for the same flops. The bench holds a fault report high during the same cycle as a fault status read, then as a fault status write, and then as a fault address write. After each one it confirms that `irq` is still 1 and that the registers read back the captured values rather than the written data.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

   localparam int DATA_W = 32;

   // fixed word indexes; slot and mask ID indexes are derived in the top
   localparam int IDX_CTRL      = 0;
   localparam int IDX_PTBASE    = 1;
   localparam int IDX_FLUSH_ALL = 2;
   localparam int IDX_FLUSH_PG  = 3;
   localparam int IDX_FSTAT     = 4;
   localparam int IDX_FADDR     = 5;
   localparam int IDX_ARB_EN    = 6;
   localparam int IDX_ARBIT     = 7;
   localparam int IDX_SLOT0     = 8;

   localparam logic [DATA_W-1:0] CTRL_WMASK    = 32'h0000_001D;
   localparam logic [DATA_W-1:0] PTBASE_WMASK  = 32'h07FF_FC00;
   localparam logic [DATA_W-1:0] ARB_EN_WMASK  = 32'h801F_000F;
   localparam logic [DATA_W-1:0] ARB_EN_FORCE  = 32'h0000_0001;
   localparam logic [DATA_W-1:0] ARB_EN_RST    = 32'h0000_0003;
   localparam logic [DATA_W-1:0] ARBIT_WMASK   = 32'h001F_0000;
   localparam logic [DATA_W-1:0] ARBIT_FORCE   = 32'h0000_0008;
   localparam logic [DATA_W-1:0] SLOT_WMASK    = 32'h0001_0003;
   localparam logic [DATA_W-1:0] MASKID_WMASK  = 32'h00FF_FFFF;
   localparam logic [DATA_W-1:0] FSTAT_WMASK   = 32'hFF0F_FFFF;

   // fault status bit positions
   localparam int FS_ERR  = 31;
   localparam int FS_LATE = 30;
   localparam int FS_RESV = 23;
   localparam int FS_RD   = 18;
   localparam int FS_AVAL = 17;

   localparam logic [DATA_W-1:0] FSTAT_RESV_BIT = DATA_W'(1) << FS_RESV;

   localparam int RANGE_LSB = 2;
   localparam int RANGE_W   = 3;
   localparam int MIN_WIN_LOG2 = 24;

   // smallest window is 16MB; each code step doubles it
   function automatic logic [DATA_W-1:0] window_base(input logic [RANGE_W-1:0] code);
      logic [DATA_W:0] size;
      size = (DATA_W+1)'(1) << (MIN_WIN_LOG2 + int'(code));
      return DATA_W'((DATA_W+1)'(1) << DATA_W) - size[DATA_W-1:0];
   endfunction

endpackage

// File: rtl/iommu_reg_decode.sv
module iommu_reg_decode #(
   parameter int ADDR_W    = 4,
   parameter int REG_COUNT = 13
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [REG_COUNT-1:0] sel
);

   generate
      if ((1 << ADDR_W) < REG_COUNT) begin : g_bad_width
         $error("iommu_reg_decode: ADDR_W too narrow for REG_COUNT");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < REG_COUNT; gi++) begin : g_sel
         assign sel[gi] = (addr == ADDR_W'(gi));
      end
   endgenerate

endmodule

// File: rtl/iommu_masked_reg.sv
module iommu_masked_reg #(
   parameter int             W     = 32,
   parameter logic [W-1:0]   WMASK = '1,
   parameter logic [W-1:0]   FORCE = '0,
   parameter logic [W-1:0]   RST   = '0,
   parameter bit             ACCUM = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   generate
      if (ACCUM) begin : g_accum
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST;
            else if (we) q <= q | (wdata & WMASK) | FORCE;
         end
      end else begin : g_replace
         always_ff @(posedge clk) begin
            if (!rst_n)  q <= RST;
            else if (we) q <= (wdata & WMASK) | FORCE;
         end
      end
   endgenerate

endmodule

// File: rtl/iommu_window.sv
module iommu_window
   import iommu_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [RANGE_W-1:0] code,
   output logic [DATA_W-1:0] win_start
);

   always_ff @(posedge clk) begin
      if (!rst_n)       win_start <= '0;
      else if (ctrl_we) win_start <= window_base(code);
   end

endmodule

// File: rtl/iommu_fault_log.sv
module iommu_fault_log
   import iommu_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_report,
   input  logic              flt_is_read,
   input  logic [DATA_W-1:0] flt_page,
   input  logic              stat_we,
   input  logic              stat_rd,
   input  logic              addr_we,
   input  logic              addr_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] addr_q,
   output logic              irq
);

   logic [DATA_W-1:0] capture;

   always_comb begin
      capture = FSTAT_RESV_BIT;
      capture[FS_ERR]  = 1'b1;
      capture[FS_LATE] = 1'b1;
      capture[FS_AVAL] = 1'b1;
      capture[FS_RD]   = flt_is_read;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= FSTAT_RESV_BIT;
         addr_q <= '0;
         irq    <= 1'b0;
      end else if (flt_report) begin
         stat_q <= capture;
         addr_q <= flt_page;
         irq    <= 1'b1;
      end else begin
         if (stat_we) stat_q <= (wdata & FSTAT_WMASK) | FSTAT_RESV_BIT;
         if (addr_we) addr_q <= wdata;
         if (stat_we || stat_rd || addr_we || addr_rd) irq <= 1'b0;
      end
   end

endmodule

// File: rtl/iommu_regs.sv
module iommu_regs
   import iommu_regs_pkg::*;
#(
   parameter int          ADDR_W      = 4,
   parameter int          NUM_SLOTS   = 4,
   parameter logic [7:0]  VERSION     = 8'h41,
   parameter logic [31:0] MASK_ID_RST = 32'h2300_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_rvalid,
   output logic [31:0]       bus_rdata,
   input  logic              flt_report,
   input  logic              flt_is_read,
   input  logic [31:0]       flt_page,
   output logic              xlate_en,
   output logic [31:0]       win_start,
   output logic [31:0]       pt_base,
   output logic              irq
);

   localparam int IDX_MASKID = IDX_SLOT0 + NUM_SLOTS;
   localparam int REG_COUNT  = IDX_MASKID + 1;
   localparam logic [DATA_W-1:0] VER_WORD = {VERSION, 24'h0};

   generate
      if (NUM_SLOTS < 1 || NUM_SLOTS > 8) begin : g_bad_slots
         $error("iommu_regs: NUM_SLOTS must be 1..8");
      end
   endgenerate

   logic [REG_COUNT-1:0] sel, wr, rd;
   logic [DATA_W-1:0]    regv [REG_COUNT];
   logic [DATA_W-1:0]    rd_mux;
   logic                 is_rd, is_wr;

   iommu_reg_decode #(.ADDR_W(ADDR_W), .REG_COUNT(REG_COUNT)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign is_wr = bus_req &&  bus_we;
   assign is_rd = bus_req && !bus_we;
   assign wr    = sel & {REG_COUNT{is_wr}};
   assign rd    = sel & {REG_COUNT{is_rd}};

   // control word with hardwired version byte
   iommu_masked_reg #(.W(DATA_W), .WMASK(CTRL_WMASK), .FORCE(VER_WORD), .RST(VER_WORD)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_CTRL]), .wdata(bus_wdata), .q(regv[IDX_CTRL])
   );

   iommu_window u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_we   (wr[IDX_CTRL]),
      .code      (bus_wdata[RANGE_LSB +: RANGE_W]),
      .win_start (win_start)
   );

   iommu_masked_reg #(.W(DATA_W), .WMASK(PTBASE_WMASK)) u_ptbase (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_PTBASE]), .wdata(bus_wdata), .q(regv[IDX_PTBASE])
   );

   iommu_masked_reg #(.W(DATA_W)) u_flush_all (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_FLUSH_ALL]), .wdata(bus_wdata), .q(regv[IDX_FLUSH_ALL])
   );

   iommu_masked_reg #(.W(DATA_W)) u_flush_pg (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_FLUSH_PG]), .wdata(bus_wdata), .q(regv[IDX_FLUSH_PG])
   );

   iommu_fault_log u_fault (
      .clk         (clk),
      .rst_n       (rst_n),
      .flt_report  (flt_report),
      .flt_is_read (flt_is_read),
      .flt_page    (flt_page),
      .stat_we     (wr[IDX_FSTAT]),
      .stat_rd     (rd[IDX_FSTAT]),
      .addr_we     (wr[IDX_FADDR]),
      .addr_rd     (rd[IDX_FADDR]),
      .wdata       (bus_wdata),
      .stat_q      (regv[IDX_FSTAT]),
      .addr_q      (regv[IDX_FADDR]),
      .irq         (irq)
   );

   iommu_masked_reg #(.W(DATA_W), .WMASK(ARB_EN_WMASK), .FORCE(ARB_EN_FORCE), .RST(ARB_EN_RST)) u_arb_en (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_ARB_EN]), .wdata(bus_wdata), .q(regv[IDX_ARB_EN])
   );

   iommu_masked_reg #(.W(DATA_W), .WMASK(ARBIT_WMASK), .FORCE(ARBIT_FORCE), .RST(ARBIT_FORCE)) u_arbit (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_ARBIT]), .wdata(bus_wdata), .q(regv[IDX_ARBIT])
   );

   genvar gs;
   generate
      for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
         iommu_masked_reg #(.W(DATA_W), .WMASK(SLOT_WMASK)) u_slot (
            .clk(clk), .rst_n(rst_n), .we(wr[IDX_SLOT0+gs]), .wdata(bus_wdata), .q(regv[IDX_SLOT0+gs])
         );
      end
   endgenerate

   iommu_masked_reg #(.W(DATA_W), .WMASK(MASKID_WMASK), .RST(MASK_ID_RST), .ACCUM(1'b1)) u_maskid (
      .clk(clk), .rst_n(rst_n), .we(wr[IDX_MASKID]), .wdata(bus_wdata), .q(regv[IDX_MASKID])
   );

   // AND-OR read mux; unmapped indexes select nothing and read zero
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < REG_COUNT; i++) begin
         rd_mux = rd_mux | (regv[i] & {DATA_W{sel[i]}});
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= is_rd;
         if (is_rd) bus_rdata <= rd_mux;
      end
   end

   assign xlate_en = regv[IDX_CTRL][0];
   assign pt_base  = regv[IDX_PTBASE];

endmodule

// File: rtl/iommu_regs_chk.sv
module iommu_regs_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rvalid,
   input logic              flt_report,
   input logic              xlate_en,
   input logic [31:0]       win_start,
   input logic              irq
);

   assert_fault_sets_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flt_report |=> irq);

   assert_irq_rise_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(flt_report));

   assert_addr_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_addr == ADDR_W'(5) && !flt_report) |=> !irq);

   assert_fault_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_report && bus_req && bus_addr == ADDR_W'(4)) |=> irq);

   assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);

   assert_no_spurious_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);

   assert_enable_by_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(xlate_en) |-> $past(bus_req && bus_we && bus_addr == ADDR_W'(0)));

   assert_window_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start == 32'h0) || (win_start[31] && win_start[23:0] == 24'h0));

endmodule

bind iommu_regs iommu_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_rvalid (bus_rvalid),
   .flt_report (flt_report),
   .xlate_en   (xlate_en),
   .win_start  (win_start),
   .irq        (irq)
);

// File: tb/tb_iommu_regs.sv
module tb_iommu_regs;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] VER_WORD = 32'h4100_0000;
   localparam logic [31:0] MID_RST  = 32'h2300_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        flt_report = 1'b0, flt_is_read = 1'b0;
   logic [31:0] flt_page = '0;
   logic        xlate_en, irq;
   logic [31:0] win_start, pt_base;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iommu_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .flt_report(flt_report), .flt_is_read(flt_is_read), .flt_page(flt_page),
      .xlate_en(xlate_en), .win_start(win_start), .pt_base(pt_base), .irq(irq)
   );

   // {req tag number, word index, write data, expected read-back}
   localparam int NV = 12;
   localparam logic [75:0] VEC [NV] = '{
      {8'd2,  4'd0,  32'hFFFF_FFFF, 32'h4100_001D},   // R2
      {8'd4,  4'd1,  32'hFFFF_FFFF, 32'h07FF_FC00},   // R4
      {8'd4,  4'd2,  32'hDEAD_BEEF, 32'hDEAD_BEEF},   // R4
      {8'd4,  4'd3,  32'h1234_5678, 32'h1234_5678},   // R4
      {8'd5,  4'd6,  32'h0000_0000, 32'h0000_0001},   // R5
      {8'd5,  4'd6,  32'hFFFF_FFFF, 32'h801F_000F},   // R5
      {8'd5,  4'd7,  32'hFFFF_FFFF, 32'h001F_0008},   // R5
      {8'd5,  4'd7,  32'h0000_0000, 32'h0000_0008},   // R5
      {8'd6,  4'd8,  32'hFFFF_FFFF, 32'h0001_0003},   // R6
      {8'd6,  4'd11, 32'h0001_0002, 32'h0001_0002},   // R6
      {8'd12, 4'd13, 32'hFFFF_FFFF, 32'h0000_0000},   // R12
      {8'd8,  4'd4,  32'hFFFF_FFFF, 32'hFF8F_FFFF}    // R8
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      d = bus_rdata;
      check("R13 rvalid", 32'(bus_rvalid), 32'd1);
   endtask

   task automatic fault(input logic rd, input logic [31:0] pg);
      flt_report = 1'b1; flt_is_read = rd; flt_page = pg;
      @(negedge clk);
      flt_report = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      check("R1 xlate_en", 32'(xlate_en), 0);
      check("R1 win_start", win_start, 0);
      check("R1 rvalid idle", 32'(bus_rvalid), 0);
      bus_read(4'd0, rv);  check("R1 ctrl", rv, VER_WORD);
      bus_read(4'd7, rv);  check("R1 arbit", rv, 32'h8);
      bus_read(4'd4, rv);  check("R1 fstat", rv, 32'h0080_0000);
      bus_read(4'd6, rv);  check("R1 arb_en", rv, 32'h3);
      bus_read(4'd12, rv); check("R1 maskid", rv, MID_RST);
      bus_read(4'd1, rv);  check("R1 ptbase", rv, 0);
      bus_read(4'd5, rv);  check("R1 faddr", rv, 0);

      // vector table: write then read back
      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i][67:64], VEC[i][63:32]);
         check("R13 rvalid after write", 32'(bus_rvalid), 0);
         bus_read(VEC[i][67:64], rv);
         checks++;
         if (rv !== VEC[i][31:0]) begin
            errors++;
            $display("FAIL R%0d vector %0d: actual %08h expected %08h",
                     VEC[i][75:68], i, rv, VEC[i][31:0]);
         end
      end
      check("R4 pt_base port", pt_base, 32'h07FF_FC00);

      // R12: unmapped writes touch nothing
      bus_write(4'd14, 32'hFFFF_FFFF);
      bus_read(4'd14, rv); check("R12 idx14", rv, 0);
      bus_read(4'd9, rv);  check("R12 slot1 untouched", rv, 0);
      bus_read(4'd2, rv);  check("R12 flush untouched", rv, 32'hDEAD_BEEF);

      // R6: slot independence
      bus_write(4'd9, 32'h0000_0001);
      bus_read(4'd10, rv); check("R6 slot2", rv, 0);
      bus_read(4'd8, rv);  check("R6 slot0", rv, 32'h0001_0003);
      bus_read(4'd9, rv);  check("R6 slot1", rv, 32'h0000_0001);

      // R3 window decode, R2 enable follows bit 0
      for (int c = 0; c < 8; c++) begin
         bus_write(4'd0, 32'(c << 2) | 32'(c & 1));
         check("R3 win_start", win_start, 32'hFFFF_FFFF << (24 + c));
         check("R2 xlate_en", 32'(xlate_en), 32'(c & 1));
      end

      // R7 mask ID accumulates
      bus_write(4'd12, 32'h0000_00FF);
      bus_read(4'd12, rv); check("R7 or1", rv, 32'h2300_00FF);
      bus_write(4'd12, 32'hFF00_FF00);
      bus_read(4'd12, rv); check("R7 or2", rv, 32'h2300_FFFF);

      // R9 fault capture on read access; R10 other reads keep irq
      fault(1'b1, 32'h00AB_C000);
      check("R9 irq set", 32'(irq), 1);
      bus_read(4'd6, rv);
      check("R10 irq kept", 32'(irq), 1);
      bus_read(4'd4, rv);
      check("R9 fstat read", rv, 32'hC086_0000);
      check("R10 stat read clears", 32'(irq), 0);
      bus_read(4'd5, rv); check("R9 faddr", rv, 32'h00AB_C000);

      // write fault; R10 address write clears and stores
      fault(1'b0, 32'h0001_2000);
      check("R9 irq write fault", 32'(irq), 1);
      bus_write(4'd5, 32'hCAFE_F00D);
      check("R10 addr write clears", 32'(irq), 0);
      bus_read(4'd5, rv); check("R10 addr stored", rv, 32'hCAFE_F00D);
      bus_read(4'd4, rv); check("R9 fstat write", rv, 32'hC082_0000);

      // R10 address read clears
      fault(1'b0, 32'h0000_3000);
      bus_read(4'd5, rv);
      check("R10 addr read clears", 32'(irq), 0);

      // R8 status write clears
      fault(1'b1, 32'h0000_4000);
      bus_write(4'd4, 32'h0000_0000);
      check("R8 stat write clears", 32'(irq), 0);
      bus_read(4'd4, rv); check("R8 stat value", rv, 32'h0080_0000);

      // R11 collisions: fault with status read
      flt_report = 1'b1; flt_is_read = 1'b1; flt_page = 32'h0000_5000;
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = 4'd4;
      @(negedge clk);
      flt_report = 1'b0; bus_req = 1'b0;
      check("R11 irq vs stat read", 32'(irq), 1);
      // fault with status write
      bus_write(4'd4, 32'h0);
      flt_report = 1'b1; flt_is_read = 1'b0; flt_page = 32'h0000_6000;
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h0F0F_0F0F;
      @(negedge clk);
      flt_report = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
      check("R11 irq vs stat write", 32'(irq), 1);
      // fault with address write
      flt_report = 1'b1; flt_is_read = 1'b1; flt_page = 32'h0000_7000;
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h1111_1111;
      @(negedge clk);
      flt_report = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
      check("R11 irq vs addr write", 32'(irq), 1);
      bus_read(4'd5, rv); check("R11 addr kept", rv, 32'h0000_7000);
      bus_read(4'd4, rv); check("R11 stat kept", rv, 32'hC086_0000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule